// File: doc/BRIEF.md
# Rectangle Copy Blitter with Raster Operation

The block executes one rectangle copy per command. A command arrives as eight 32-bit words on a valid/ready stream. It names a destination rectangle, a source origin, two base addresses and two byte pitches. For every destination pixel, in row-major order starting at the top-left corner, the block reads the source pixel and the current destination pixel. It combines them bit by bit through an 8-bit raster-operation truth table and writes the result back. Byte enables on the write carry the pixel's lanes.

Memory is flat and byte addressed, and the ports carry word addresses. A pixel is 1, 2 or 4 bytes and never crosses a 32-bit word. For 4-byte pixels, two flags in the first command word gate the alpha byte and the colour bytes separately. A rectangle with no area completes at once and writes nothing. One done pulse marks the end of each command.

Top module: `blit_copy_top`

## Requirements
- R1: Command words are taken in this order: word0 opcode/flags, word1 control, word2 destination top-left, word3 destination bottom-right (exclusive), word4 destination base byte address, word5 source top-left, word6 source pitch (bits 15:0), word7 source base byte address. cmd_ready is high whenever no command executes, is low while one executes, and is never high during a write. Accepting word7 starts the command.
- R2: Coordinate words hold y in bits 31:16 and x in bits 15:0. Destination pixels are written one per write in row-major order, x rising within a row and rows rising from y1. There is exactly one write for each pixel with x1 <= x < x2 and y1 <= y < y2. Reads and writes never occur in the same cycle.
- R3: Bytes per pixel come from control bits 25:24: 00 gives 1, 01 gives 2, and 10 or 11 give 4. The byte address of a pixel is base + y*pitch + x*bpp. The port address is that byte address shifted right by two, and the first lane is its two low bits.
- R4: Bits 1:0 of both pitches are ignored, as if they were zero. The destination pitch is control bits 15:0.
- R5: The raster code is control bits 23:16. Each result bit equals code bit number 2*s + d, where s is the source bit and d is the destination bit. So 0xCC copies, 0x00 clears, 0xFF sets, 0x66 is XOR, 0x88 is AND, 0xEE is OR, 0x55 inverts the destination and 0xAA keeps it.
- R6: With 1- or 2-byte pixels, exactly the pixel's lanes are enabled. With 4-byte pixels, word0 bit 21 enables lane 3 (alpha) and word0 bit 20 enables lanes 2..0 (colour). With neither bit set, the write carries no enabled lane.
- R7: If x2 <= x1 or y2 <= y1 (unsigned), no read or write occurs and done pulses in the cycle after word7 is accepted.
- R8: done is a one-cycle pulse in the cycle after the last write is accepted. While wr_en is high and wr_ready low, wr_addr, wr_data and wr_be hold.
- R9: Source bytes are moved from their own lane offset to the destination pixel's lane offset before the raster operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Command word accepted when high with cmd_valid |
| cmd_word | input | 32 | Command word |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | AW-2 | Read word address |
| rd_data | input | 32 | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Memory write request |
| wr_ready | input | 1 | Write accepted when high with wr_en |
| wr_addr | output | AW-2 | Write word address |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Write byte enables |
| done | output | 1 | One-cycle completion pulse |

## Verification
Read data arrives one cycle after rd_en. A pixel takes at least four cycles: source read, destination read, result capture and write. done is due exactly one cycle after the accepting edge of the last write, or of word7 for an empty rectangle. cmd_ready returns in that same cycle.

The bench drives its inputs just after the rising edge and compares at the falling edge. At each falling edge it predicts, from what it saw at the previous falling edge, what done and cmd_ready must be. Each accepted write is compared against the head of a queue that a byte-level model filled when word7 was accepted.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSRC,
    ST_RDST,
    ST_CALC,
    ST_WRITE
  } walk_state_t;

  typedef struct packed {
    logic        wr_alpha;
    logic        wr_rgb;
    logic [7:0]  rop;
    logic [1:0]  depth;
    logic [15:0] dpitch;
    logic [15:0] dx1;
    logic [15:0] dy1;
    logic [15:0] dx2;
    logic [15:0] dy2;
    logic [31:0] dbase;
    logic [15:0] sx;
    logic [15:0] sy;
    logic [15:0] spitch;
    logic [31:0] sbase;
  } blit_cmd_t;

  function automatic logic [2:0] bpp_of(input logic [1:0] depth);
    case (depth)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [7:0] rop_byte(input logic [7:0] code,
                                          input logic [7:0] s,
                                          input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = code[{s[i], d[i]}];
    return r;
  endfunction

  function automatic logic [31:0] byte_addr(input logic [31:0] base,
                                            input logic [15:0] x,
                                            input logic [15:0] y,
                                            input logic [15:0] pitch,
                                            input logic [2:0]  bpp);
    return base + 32'(y) * 32'({pitch[15:2], 2'b00}) + 32'(x) * 32'(bpp);
  endfunction

endpackage

// File: rtl/blit_cmd_collect.sv
module blit_cmd_collect
  import blit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_word,
  input  logic        engine_idle,
  output logic        cmd_ready,
  output logic        go,
  output blit_cmd_t   cmd
);
  localparam int NWORDS = 8;
  localparam int CNTW   = $clog2(NWORDS);

  logic [CNTW-1:0] cnt;
  logic [31:0]     hold [NWORDS-1];
  logic            accept;
  logic            unused_bits;

  assign cmd_ready = engine_idle;
  assign accept    = cmd_valid && cmd_ready;
  assign go        = accept && (cnt == CNTW'(NWORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < NWORDS - 1; i++) hold[i] <= '0;
    end else if (accept) begin
      cnt <= cnt + 1'b1;
      if (!go) hold[cnt] <= cmd_word;
    end
  end

  always_comb begin
    cmd.wr_alpha = hold[0][21];
    cmd.wr_rgb   = hold[0][20];
    cmd.rop      = hold[1][23:16];
    cmd.depth    = hold[1][25:24];
    cmd.dpitch   = hold[1][15:0];
    cmd.dx1      = hold[2][15:0];
    cmd.dy1      = hold[2][31:16];
    cmd.dx2      = hold[3][15:0];
    cmd.dy2      = hold[3][31:16];
    cmd.dbase    = hold[4];
    cmd.sx       = hold[5][15:0];
    cmd.sy       = hold[5][31:16];
    cmd.spitch   = hold[6][15:0];
    cmd.sbase    = cmd_word;
  end

  assign unused_bits = ^{hold[0][31:22], hold[0][19:0], hold[1][31:26], hold[6][31:16]};

endmodule

// File: rtl/blit_lane_path.sv
module blit_lane_path
  import blit_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] src_word,
  input  logic [8*LANES-1:0] dst_word,
  input  logic [1:0]         src_lane,
  input  logic [1:0]         dst_lane,
  input  logic [7:0]         rop,
  input  logic [2:0]         bpp,
  input  logic               wr_alpha,
  input  logic               wr_rgb,
  output logic [8*LANES-1:0] res_word,
  output logic [LANES-1:0]   res_be
);
  localparam int W = 8 * LANES;

  logic [W-1:0]     aligned;
  logic [LANES-1:0] pix_mask;

  assign aligned = (src_word >> {src_lane, 3'b000}) << {dst_lane, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign res_word[8*g +: 8] = rop_byte(rop, aligned[8*g +: 8], dst_word[8*g +: 8]);
  end

  always_comb begin
    case (bpp)
      3'd1:    pix_mask = LANES'(4'b0001);
      3'd2:    pix_mask = LANES'(4'b0011);
      default: pix_mask = LANES'({wr_alpha, wr_rgb, wr_rgb, wr_rgb});
    endcase
  end

  assign res_be = pix_mask << dst_lane;

endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  blit_cmd_t     cmd,
  output logic          idle,
  output logic          rd_en,
  output logic [AW-3:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  input  logic          wr_ready,
  output logic [AW-3:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_be,
  output logic          done
);
  localparam int WAW = AW - 2;

  walk_state_t st;
  blit_cmd_t   cur;
  logic [15:0] x, y;
  logic [31:0] src_q, wdata_q;
  logic [3:0]  wbe_q;
  logic [WAW-1:0] waddr_q;
  logic        done_q;

  logic [2:0]  bpp;
  logic [15:0] sxc, syc;
  logic [31:0] saddr, daddr;
  logic [31:0] lane_data;
  logic [3:0]  lane_be;
  logic        go_empty, x_end, last_pix, wr_accept;
  logic        unused_addr;

  assign bpp      = bpp_of(cur.depth);
  assign sxc      = cur.sx + (x - cur.dx1);
  assign syc      = cur.sy + (y - cur.dy1);
  assign saddr    = byte_addr(cur.sbase, sxc, syc, cur.spitch, bpp);
  assign daddr    = byte_addr(cur.dbase, x, y, cur.dpitch, bpp);
  assign go_empty = go && ((cmd.dx2 <= cmd.dx1) || (cmd.dy2 <= cmd.dy1));
  assign x_end    = (x + 16'd1) == cur.dx2;
  assign last_pix = x_end && ((y + 16'd1) == cur.dy2);
  assign wr_accept = wr_en && wr_ready;

  blit_lane_path #(.LANES(4)) u_lane (
    .src_word (src_q),
    .dst_word (rd_data),
    .src_lane (saddr[1:0]),
    .dst_lane (daddr[1:0]),
    .rop      (cur.rop),
    .bpp      (bpp),
    .wr_alpha (cur.wr_alpha),
    .wr_rgb   (cur.wr_rgb),
    .res_word (lane_data),
    .res_be   (lane_be)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur     <= '0;
      x       <= '0;
      y       <= '0;
      src_q   <= '0;
      wdata_q <= '0;
      wbe_q   <= '0;
      waddr_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            cur <= cmd;
            x   <= cmd.dx1;
            y   <= cmd.dy1;
            if (go_empty) done_q <= 1'b1;
            else          st     <= ST_RSRC;
          end
        end
        ST_RSRC: st <= ST_RDST;
        ST_RDST: begin
          src_q <= rd_data;
          st    <= ST_CALC;
        end
        ST_CALC: begin
          wdata_q <= lane_data;
          wbe_q   <= lane_be;
          waddr_q <= daddr[AW-1:2];
          st      <= ST_WRITE;
        end
        ST_WRITE: begin
          if (wr_ready) begin
            if (last_pix) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              st <= ST_RSRC;
              if (x_end) begin
                x <= cur.dx1;
                y <= y + 16'd1;
              end else begin
                x <= x + 16'd1;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (st == ST_IDLE);
  assign rd_en   = (st == ST_RSRC) || (st == ST_RDST);
  assign rd_addr = (st == ST_RSRC) ? saddr[AW-1:2] : daddr[AW-1:2];
  assign wr_en   = (st == ST_WRITE);
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;
  assign wr_be   = wbe_q;
  assign done    = done_q;

  assign unused_addr = ^{saddr[31:AW], daddr[31:AW]};

  AST_NO_RD_DURING_WR: assert property (@(posedge clk) disable iff (!rst_n) !(rd_en && wr_en)); // R2
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) go_empty |=> (done && !wr_en && !rd_en)); // R7
  AST_BE_WITHIN_PIXEL: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> ($countones(wr_be) <= int'(bpp))); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_ready) |=> (wr_en && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(wr_accept) || $past(go_empty))); // R8

endmodule

// File: rtl/blit_copy_top.sv
module blit_copy_top
  import blit_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [31:0]   cmd_word,
  output logic          rd_en,
  output logic [AW-3:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  input  logic          wr_ready,
  output logic [AW-3:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_be,
  output logic          done
);
  blit_cmd_t cmd;
  logic      go;
  logic      eng_idle;

  blit_cmd_collect u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .engine_idle (eng_idle),
    .cmd_ready   (cmd_ready),
    .go          (go),
    .cmd         (cmd)
  );

  blit_walker #(.AW(AW)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .cmd      (cmd),
    .idle     (eng_idle),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .done     (done)
  );

  AST_NO_CMD_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !cmd_ready); // R1
  AST_GO_STARTS_WORK: assert property (@(posedge clk) disable iff (!rst_n) (go && !done) |=> (rd_en || done)); // R1

endmodule

// File: tb/tb_blit_copy_top.sv
module tb_blit_copy_top;
  localparam int AW = 12;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, cmd_valid, cmd_ready, rd_en, wr_en, wr_ready, done;
  logic [31:0]   cmd_word, rd_data, wr_data;
  logic [AW-3:0] rd_addr, wr_addr;
  logic [3:0]    wr_be;

  blit_copy_top #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .done(done)
  );

  logic [7:0] mem  [NB];
  logic [7:0] refb [NB];

  int ntests = 0, nfail = 0;
  int cyc = 0;
  bit stall = 0;
  bit busy_m = 0, done_pend = 0, running = 0;
  int wcnt = 0;
  logic [31:0] seen [8];
  logic [31:0] cw [8];
  string tag = "R1";
  int          q_addr [$];
  logic [3:0]  q_be   [$];
  logic [31:0] q_data [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) rd_data <= {mem[{rd_addr, 2'd3}], mem[{rd_addr, 2'd2}],
                           mem[{rd_addr, 2'd1}], mem[{rd_addr, 2'd0}]};
    if (wr_en && wr_ready)
      for (int k = 0; k < 4; k++)
        if (wr_be[k]) mem[{wr_addr, 2'(k)}] <= wr_data[8*k +: 8];
  end

  always @(posedge clk) begin
    #1;
    wr_ready = stall ? ((cyc % 3) != 0) : 1'b1;
  end

  function automatic void model();
    int dep, bpp, dp, sp, x1, y1, x2, y2, sx0, sy0, db, sb;
    bit al, rg;
    logic [7:0] rop;
    al  = seen[0][21]; rg = seen[0][20];
    rop = seen[1][23:16]; dep = int'(seen[1][25:24]);
    bpp = (dep == 0) ? 1 : (dep == 1) ? 2 : 4;
    dp  = int'(seen[1][15:0]) & 'hFFFC;
    sp  = int'(seen[6][15:0]) & 'hFFFC;
    x1 = int'(seen[2][15:0]); y1 = int'(seen[2][31:16]);
    x2 = int'(seen[3][15:0]); y2 = int'(seen[3][31:16]);
    db = int'(seen[4]); sx0 = int'(seen[5][15:0]); sy0 = int'(seen[5][31:16]);
    sb = int'(seen[7]);
    if (x2 <= x1 || y2 <= y1) begin
      done_pend = 1;
      return;
    end
    busy_m = 1;
    for (int yy = y1; yy < y2; yy++)
      for (int xx = x1; xx < x2; xx++) begin
        int sa, da;
        logic [31:0] wd;
        logic [3:0]  be;
        sa = (sb + (sy0 + yy - y1) * sp + (sx0 + xx - x1) * bpp) % NB;
        da = (db + yy * dp + xx * bpp) % NB;
        wd = 0; be = 0;
        for (int k = 0; k < bpp; k++) begin
          logic [7:0] s, d, r;
          bit en;
          int ln;
          s = refb[(sa + k) % NB]; d = refb[(da + k) % NB];
          for (int b = 0; b < 8; b++) r[b] = rop[2 * s[b] + d[b]];
          en = (bpp == 4) ? ((k == 3) ? al : rg) : 1'b1;
          ln = (da + k) % 4;
          if (en) begin
            be[ln] = 1'b1;
            wd[8*ln +: 8] = r;
            refb[(da + k) % NB] = r;
          end
        end
        q_addr.push_back(da / 4);
        q_be.push_back(be);
        q_data.push_back(wd);
      end
  endfunction

  always @(negedge clk) begin
    if (running) begin
      bit exp_done;
      exp_done = done_pend;
      done_pend = 0;
      chk(done === exp_done, tag, "done timing", 32'(done), 32'(exp_done));
      chk(cmd_ready === !busy_m, "R1", "cmd_ready", 32'(cmd_ready), 32'(!busy_m));
      if (wr_en && wr_ready) begin
        if (q_addr.size() == 0) begin
          chk(0, tag, "unexpected write", 32'(wr_addr), 32'hFFFFFFFF);
        end else begin
          int a;
          logic [3:0] be;
          logic [31:0] d;
          a = q_addr.pop_front(); be = q_be.pop_front(); d = q_data.pop_front();
          chk(int'(wr_addr) == a, tag, "R2/R3 write address", 32'(wr_addr), 32'(a));
          chk(wr_be === be, tag, "R6 byte enables", 32'(wr_be), 32'(be));
          for (int k = 0; k < 4; k++)
            if (be[k])
              chk(wr_data[8*k +: 8] === d[8*k +: 8], tag, "R5/R9 write data",
                  wr_data, d);
          if (q_addr.size() == 0) begin
            busy_m = 0;
            done_pend = 1;
          end
        end
      end
      if (cmd_valid && cmd_ready) begin
        seen[wcnt] = cmd_word;
        wcnt++;
        if (wcnt == 8) begin
          wcnt = 0;
          model();
        end
      end
    end
  end

  task automatic run_cmd(input logic [31:0] opc, input logic [31:0] ctl,
                         input int dx1, input int dy1, input int dx2, input int dy2,
                         input int dbase, input int sx, input int sy,
                         input int spitch, input int sbase, input string t);
    tag = t;
    cw[0] = opc; cw[1] = ctl;
    cw[2] = {16'(dy1), 16'(dx1)}; cw[3] = {16'(dy2), 16'(dx2)};
    cw[4] = 32'(dbase); cw[5] = {16'(sy), 16'(sx)};
    cw[6] = 32'(spitch); cw[7] = 32'(sbase);
    for (int i = 0; i < 8; i++) begin
      cmd_valid = 1'b1;
      cmd_word  = cw[i];
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    while (busy_m) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl_of(input int dep, input logic [7:0] rop, input int pitch);
    return {6'b0, 2'(dep), rop, 16'(pitch)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      mem[i]  = 8'((i * 37 + 11) ^ (i >> 3));
      refb[i] = 8'((i * 37 + 11) ^ (i >> 3));
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; wr_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R1", "reset cmd_ready", 32'(cmd_ready), 1);
    chk(wr_en === 1'b0 && rd_en === 1'b0, "R1", "reset no access", 32'({rd_en, wr_en}), 0);
    chk(done === 1'b0, "R8", "reset done", 32'(done), 0);
    running = 1;
    @(posedge clk); #1;
    // R3 R5: copy, 4 byte pixels, both lane groups enabled
    run_cmd(32'h0030_0000, ctl_of(3, 8'hCC, 64), 2, 1, 5, 3, 'h800, 1, 2, 32, 'h100, "R5");
    // R9: 1 byte pixels, XOR, source and destination lanes differ
    run_cmd(32'h0, ctl_of(0, 8'h66, 16), 3, 0, 8, 3, 'h900, 6, 1, 20, 'h200, "R9");
    // R5 R9: 2 byte pixels, AND, lane shift by two
    run_cmd(32'h0, ctl_of(1, 8'h88, 24), 1, 2, 4, 4, 'hA00, 2, 0, 12, 'h300, "R9");
    // R6: alpha lane only, set
    run_cmd(32'h0020_0000, ctl_of(3, 8'hFF, 32), 0, 0, 3, 2, 'hB00, 0, 0, 16, 'h400, "R6");
    // R6: colour lanes only, invert destination
    run_cmd(32'h0010_0000, ctl_of(3, 8'h55, 32), 1, 0, 3, 2, 'hB80, 0, 1, 16, 'h400, "R6");
    // R6: neither flag, no lane enabled
    run_cmd(32'h0, ctl_of(3, 8'hCC, 16), 0, 0, 2, 1, 'hC00, 0, 0, 16, 'h500, "R6");
    // R4: pitches with low bits set
    run_cmd(32'h0, ctl_of(0, 8'hEE, 19), 0, 0, 4, 3, 'hD00, 1, 1, 22, 'h600, "R4");
    // R8: write stalls, keep destination and clear
    stall = 1;
    run_cmd(32'h0030_0000, ctl_of(3, 8'hAA, 32), 0, 0, 3, 2, 'hE00, 0, 0, 16, 'h100, "R8");
    run_cmd(32'h0, ctl_of(1, 8'h00, 16), 1, 1, 4, 3, 'hE80, 0, 0, 16, 'h180, "R8");
    stall = 0;
    // R7: empty rectangles
    run_cmd(32'h0030_0000, ctl_of(3, 8'hCC, 16), 4, 0, 4, 5, 'hF00, 0, 0, 16, 'h100, "R7");
    run_cmd(32'h0030_0000, ctl_of(3, 8'hCC, 16), 0, 6, 4, 2, 'hF00, 0, 0, 16, 'h100, "R7");
    // R3: depth code 10 selects 4 byte pixels, OR
    run_cmd(32'h0030_0000, ctl_of(2, 8'hEE, 32), 1, 1, 3, 2, 'hF40, 0, 0, 16, 'h700, "R3");
    // R2: single pixel
    run_cmd(32'h0, ctl_of(0, 8'hCC, 8), 5, 3, 6, 4, 'hFC0, 7, 2, 8, 'h780, "R2");
    chk(q_addr.size() == 0, "R2", "all writes seen", 32'(q_addr.size()), 0);
    for (int i = 0; i < NB; i++)
      if (mem[i] !== refb[i]) chk(0, "R2", "final memory byte", 32'(mem[i]), 32'(refb[i]));
    running = 0;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule